// File: doc/BRIEF.md
# Rail Supervisor and Enable Logic

This block is the always-on digital control of a power manager that feeds six rails: two switching converters (CONV_A and CONV_B) and four linear regulators (LIN_1 to LIN_4). For each rail it forms the enable from an external pin and a register bit. It gates the enables during undervoltage lockout and during converter or linear-regulator over-temperature. Each over-temperature flag acts on its own rail group.

When undervoltage lockout releases, the block decodes two three-level strap pins into one of nine default voltage-code sets and loads them into writable code registers. It also drives two open-drain control outputs from register bits. It drives a threshold pull-down output. It assembles a read-only status byte from the regulators' power-good flags, the threshold comparator and the CONV_B ramp flag.

Software reaches the registers through a plain write strobe with address and data, and through a combinational read port.

Top module: `rail_supervisor`

## Requirements
- R1: Each enable `rail_en_o[i]` equals `rail_pin_i[i]` XOR control-register bit i. The bit order is: bit 5 CONV_A, bit 4 CONV_B, bits 3..0 LIN_1..LIN_4.
- R2: While `uvlo_i` is 1, every enable is 0. The control register is cleared to 0x00 and register writes have no effect.
- R3: While `therm_conv_i` is 1, enables 5 and 4 are 0 and the linear rails are unaffected. The converter enables return when the flag clears.
- R4: While `therm_lin_i` is 1, enables 3..0 are 0 and the converters are unaffected.
- R5: Control bit 7 drives `rst_ctl_o` and bit 6 drives `pd_ctl_o`. A 0 means the output pulls low. Both are 0 out of reset and during lockout.
- R6: Each strap pin arrives as {hi, flt}. Level 0 is low, 1 is float and 2 is high, and flt=1 means float whatever hi is. The set index is 3*level(B) + level(A). Index 0..8 gives LIN_4 codes 2,6,2,6,3,6,0,7,0 and CONV_A codes 42,36,36,42,42,16,38,42,16. LIN_1, LIN_2 and LIN_3 are 2,2,7 except at index 8, where they are 1,0,1.
- R7: The codes load at the first clock edge where `uvlo_i` is 0 after being 1, or the first edge after reset. After that, strap changes have no effect and writes replace the codes.
- R8: The status byte has bit 7 = `thr_above_i` and bit 6 = `ramp_busy_i`. Bits 5..0 are 1 (not good) when a rail is disabled or its power-good is 0.
- R9: `thr_pull_o` is 1 when the misc-register gate bit is 1, `thr_above_i` is 0 and `uvlo_i` is 0. The gate bit is 1 after reset and during lockout.
- R10: The register map is: 0 status (read-only), 1 control, 2 {00,LIN_1,LIN_2}, 3 {00,LIN_3,LIN_4}, 4 {00,CONV_A}, 5 {0000000,gate}. All other addresses read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low reset |
| uvlo_i | input | 1 | 1 while supply is below lockout threshold |
| rail_pin_i | input | 6 | Enable pins, bit 5 CONV_A .. bit 0 LIN_4 |
| therm_conv_i | input | 1 | Converter over-temperature flag |
| therm_lin_i | input | 1 | Linear-regulator over-temperature flag |
| strap_a_i | input | 2 | Strap pin A as {hi, flt} |
| strap_b_i | input | 2 | Strap pin B as {hi, flt} |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| pgood_i | input | 6 | Power-good per rail, same order as enables |
| thr_above_i | input | 1 | Threshold comparator: 1 = input above 1 V |
| ramp_busy_i | input | 1 | CONV_B code ramp in progress |
| rail_en_o | output | 6 | Rail enables |
| rst_ctl_o | output | 1 | Open-drain control A, 0 = pull low |
| pd_ctl_o | output | 1 | Open-drain control B, 0 = pull low |
| thr_pull_o | output | 1 | Threshold output pull-down active |
| status_o | output | 8 | Status byte |
| lin_code_o | output | 12 | Codes {LIN_1,LIN_2,LIN_3,LIN_4}, 3 bits each |
| conva_code_o | output | 6 | CONV_A voltage code |

## Verification
The bench builds the block with the default address width of 3. With that width, all eight addresses, including the two unmapped ones, are reachable by random reads and writes. All nine strap combinations are walked through lockout cycles. Each combination uses the "float dominates" encoding with hi both 0 and 1. Random pin, thermal and control-bit mixes then cover every XOR combination while either rail group is gated.

// File: rtl/rail_sup_pkg.sv
package rail_sup_pkg;
  localparam int LIN_CW  = 3;
  localparam int CONV_CW = 6;
  localparam int DATA_W  = 8;

  typedef enum logic [1:0] {TRI_LO = 2'd0, TRI_FLT = 2'd1, TRI_HI = 2'd2} tri_lvl_e;

  typedef struct packed {
    logic [LIN_CW-1:0]  lin1;
    logic [LIN_CW-1:0]  lin2;
    logic [LIN_CW-1:0]  lin3;
    logic [LIN_CW-1:0]  lin4;
    logic [CONV_CW-1:0] conva;
  } dflt_set_t;

  // pin = {hi, flt}; float dominates
  function automatic tri_lvl_e tri_decode(logic [1:0] pin);
    if (pin[0]) return TRI_FLT;
    return pin[1] ? TRI_HI : TRI_LO;
  endfunction

  function automatic dflt_set_t dflt_lookup(tri_lvl_e b, tri_lvl_e a);
    dflt_set_t s;
    int unsigned idx;
    idx = 3 * int'(b) + int'(a);
    s.lin1 = 3'd2; s.lin2 = 3'd2; s.lin3 = 3'd7;
    case (idx)
      0: begin s.lin4 = 3'd2; s.conva = 6'd42; end
      1: begin s.lin4 = 3'd6; s.conva = 6'd36; end
      2: begin s.lin4 = 3'd2; s.conva = 6'd36; end
      3: begin s.lin4 = 3'd6; s.conva = 6'd42; end
      4: begin s.lin4 = 3'd3; s.conva = 6'd42; end
      5: begin s.lin4 = 3'd6; s.conva = 6'd16; end
      6: begin s.lin4 = 3'd0; s.conva = 6'd38; end
      7: begin s.lin4 = 3'd7; s.conva = 6'd42; end
      default: begin
        s.lin1 = 3'd1; s.lin2 = 3'd0; s.lin3 = 3'd1;
        s.lin4 = 3'd0; s.conva = 6'd16;
      end
    endcase
    return s;
  endfunction
endpackage

// File: rtl/strap_latch.sv
module strap_latch
  import rail_sup_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      uvlo_i,
  input  logic [1:0] strap_a_i,
  input  logic [1:0] strap_b_i,
  output logic      load_o,
  output dflt_set_t dflt_o
);
  logic uvlo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uvlo_q <= 1'b1;
    else        uvlo_q <= uvlo_i;
  end

  assign load_o = uvlo_q & ~uvlo_i;
  assign dflt_o = dflt_lookup(tri_decode(strap_b_i), tri_decode(strap_a_i));

  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o) else $error("load pulse longer than one cycle"); // R7
endmodule

// File: rtl/rail_gate.sv
module rail_gate #(
  parameter int N_CONV = 2,
  parameter int N_LIN  = 4,
  localparam int N_RAIL = N_CONV + N_LIN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uvlo_i,
  input  logic              therm_conv_i,
  input  logic              therm_lin_i,
  input  logic [N_RAIL-1:0] pin_i,
  input  logic [N_RAIL-1:0] bit_i,
  output logic [N_RAIL-1:0] en_o
);
  for (genvar i = 0; i < N_RAIL; i++) begin : g_rail
    logic grp_hot;
    if (i >= N_LIN) begin : g_conv
      assign grp_hot = therm_conv_i;
    end else begin : g_lin
      assign grp_hot = therm_lin_i;
    end
    assign en_o[i] = ~uvlo_i & ~grp_hot & (pin_i[i] ^ bit_i[i]);
  end

  AST_UVLO_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_i |-> (en_o == '0)) else $error("rail on in lockout"); // R2
  AST_CONV_HOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    therm_conv_i |-> (en_o[N_RAIL-1:N_LIN] == '0)) else $error("converter on while hot"); // R3
  AST_LIN_HOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    therm_lin_i |-> (en_o[N_LIN-1:0] == '0)) else $error("linear on while hot"); // R4
endmodule

// File: rtl/sup_regs.sv
module sup_regs
  import rail_sup_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uvlo_i,
  input  logic              load_i,
  input  dflt_set_t         dflt_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] status_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              gate_o,
  output dflt_set_t         codes_o
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_L12  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_L34  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CVA  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_MISC = ADDR_W'(5);

  logic [DATA_W-1:0] ctrl_q;
  logic              gate_q;
  dflt_set_t         codes_q;
  logic              wr_ok;

  assign wr_ok = wr_en_i & ~uvlo_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      gate_q  <= 1'b1;
      codes_q <= '0;
    end else if (uvlo_i) begin
      ctrl_q <= '0;
      gate_q <= 1'b1;
    end else if (load_i) begin
      codes_q <= dflt_i;
    end else if (wr_ok) begin
      case (wr_addr_i)
        A_CTRL: ctrl_q <= wr_data_i;
        A_L12:  {codes_q.lin1, codes_q.lin2} <= wr_data_i[5:0];
        A_L34:  {codes_q.lin3, codes_q.lin4} <= wr_data_i[5:0];
        A_CVA:  codes_q.conva <= wr_data_i[CONV_CW-1:0];
        A_MISC: gate_q <= wr_data_i[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_addr_i)
      A_STAT:  rd_data_o = status_i;
      A_CTRL:  rd_data_o = ctrl_q;
      A_L12:   rd_data_o = {2'b00, codes_q.lin1, codes_q.lin2};
      A_L34:   rd_data_o = {2'b00, codes_q.lin3, codes_q.lin4};
      A_CVA:   rd_data_o = {2'b00, codes_q.conva};
      A_MISC:  rd_data_o = {7'd0, gate_q};
      default: rd_data_o = '0;
    endcase
  end

  assign ctrl_o  = ctrl_q;
  assign gate_o  = gate_q;
  assign codes_o = codes_q;

  AST_CTRL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_i |=> (ctrl_q == '0)) else $error("control not cleared in lockout"); // R2
  AST_CODE_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (codes_q == $past(dflt_i))) else $error("defaults not loaded"); // R6
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !wr_en_i) |=> $stable(codes_q)) else $error("codes moved"); // R7
endmodule

// File: rtl/rail_supervisor.sv
module rail_supervisor
  import rail_sup_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uvlo_i,
  input  logic [5:0]        rail_pin_i,
  input  logic              therm_conv_i,
  input  logic              therm_lin_i,
  input  logic [1:0]        strap_a_i,
  input  logic [1:0]        strap_b_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  input  logic [5:0]        pgood_i,
  input  logic              thr_above_i,
  input  logic              ramp_busy_i,
  output logic [5:0]        rail_en_o,
  output logic              rst_ctl_o,
  output logic              pd_ctl_o,
  output logic              thr_pull_o,
  output logic [7:0]        status_o,
  output logic [11:0]       lin_code_o,
  output logic [5:0]        conva_code_o
);
  localparam int N_CONV = 2;
  localparam int N_LIN  = 4;
  localparam int N_RAIL = N_CONV + N_LIN;

  logic              load_w;
  dflt_set_t         dflt_w;
  dflt_set_t         codes_w;
  logic [DATA_W-1:0] ctrl_w;
  logic              gate_w;
  logic [N_RAIL-1:0] not_good_w;

  strap_latch u_strap (
    .clk(clk), .rst_n(rst_n), .uvlo_i(uvlo_i),
    .strap_a_i(strap_a_i), .strap_b_i(strap_b_i),
    .load_o(load_w), .dflt_o(dflt_w)
  );

  sup_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .uvlo_i(uvlo_i),
    .load_i(load_w), .dflt_i(dflt_w),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .status_i(status_o), .rd_data_o(rd_data_o),
    .ctrl_o(ctrl_w), .gate_o(gate_w), .codes_o(codes_w)
  );

  rail_gate #(.N_CONV(N_CONV), .N_LIN(N_LIN)) u_gate (
    .clk(clk), .rst_n(rst_n), .uvlo_i(uvlo_i),
    .therm_conv_i(therm_conv_i), .therm_lin_i(therm_lin_i),
    .pin_i(rail_pin_i), .bit_i(ctrl_w[N_RAIL-1:0]), .en_o(rail_en_o)
  );

  assign not_good_w   = ~(pgood_i & rail_en_o);
  assign status_o     = {thr_above_i, ramp_busy_i, not_good_w};
  assign rst_ctl_o    = ctrl_w[7];
  assign pd_ctl_o     = ctrl_w[6];
  assign thr_pull_o   = gate_w & ~thr_above_i & ~uvlo_i;
  assign lin_code_o   = {codes_w.lin1, codes_w.lin2, codes_w.lin3, codes_w.lin4};
  assign conva_code_o = codes_w.conva;

  AST_OFF_IS_NOT_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    ((~rail_en_o & ~status_o[5:0]) == '0)) else $error("disabled rail reported good"); // R8
  AST_LOCKOUT_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_i |=> (!rst_ctl_o && !pd_ctl_o)) else $error("control outputs released in lockout"); // R5
endmodule

// File: tb/sim_rail_supervisor.sv
module sim_rail_supervisor;
  logic clk = 0, rst_n = 0;
  logic uvlo, therm_c, therm_l, wr_en, thr, ramp;
  logic [5:0] pins, pgood, en;
  logic [1:0] sa, sb;
  logic [2:0] wa, ra;
  logic [7:0] wd, rd, st;
  logic rst_c, pd_c, tpull;
  logic [11:0] lin;
  logic [5:0] cva;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model
  logic [7:0] m_ctrl;
  logic       m_gate;
  logic [2:0] m_l1, m_l2, m_l3, m_l4;
  logic [5:0] m_cva;

  always #2 clk = ~clk;

  rail_supervisor u0 (
    .clk(clk), .rst_n(rst_n), .uvlo_i(uvlo), .rail_pin_i(pins),
    .therm_conv_i(therm_c), .therm_lin_i(therm_l),
    .strap_a_i(sa), .strap_b_i(sb),
    .wr_en_i(wr_en), .wr_addr_i(wa), .wr_data_i(wd),
    .rd_addr_i(ra), .rd_data_o(rd),
    .pgood_i(pgood), .thr_above_i(thr), .ramp_busy_i(ramp),
    .rail_en_o(en), .rst_ctl_o(rst_c), .pd_ctl_o(pd_c), .thr_pull_o(tpull),
    .status_o(st), .lin_code_o(lin), .conva_code_o(cva)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int lvl(logic [1:0] p);
    return p[0] ? 1 : (p[1] ? 2 : 0);
  endfunction

  function automatic void model_load(logic [1:0] b, logic [1:0] a);
    int k;
    logic [2:0] t4 [9] = '{3'd2, 3'd6, 3'd2, 3'd6, 3'd3, 3'd6, 3'd0, 3'd7, 3'd0};
    logic [5:0] tc [9] = '{6'd42, 6'd36, 6'd36, 6'd42, 6'd42, 6'd16, 6'd38, 6'd42, 6'd16};
    k = lvl(b) * 3 + lvl(a);
    m_l4 = t4[k];
    m_cva = tc[k];
    if (k == 8) begin m_l1 = 3'd1; m_l2 = 3'd0; m_l3 = 3'd1; end
    else begin m_l1 = 3'd2; m_l2 = 3'd2; m_l3 = 3'd7; end
  endfunction

  function automatic logic [5:0] exp_en();
    logic [5:0] e;
    e = pins ^ m_ctrl[5:0];
    if (uvlo) e = 6'd0;
    if (therm_c) e[5:4] = 2'b00;
    if (therm_l) e[3:0] = 4'b0000;
    return e;
  endfunction

  function automatic logic [7:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0: return {thr, ramp, ~(pgood & exp_en())};
      3'd1: return m_ctrl;
      3'd2: return {2'b00, m_l1, m_l2};
      3'd3: return {2'b00, m_l3, m_l4};
      3'd4: return {2'b00, m_cva};
      3'd5: return {7'd0, m_gate};
      default: return 8'h00;
    endcase
  endfunction

  function automatic void model_write();
    if (!wr_en || uvlo) return;
    case (wa)
      3'd1: m_ctrl = wd;
      3'd2: {m_l1, m_l2} = wd[5:0];
      3'd3: {m_l3, m_l4} = wd[5:0];
      3'd4: m_cva = wd[5:0];
      3'd5: m_gate = wd[0];
      default: ;
    endcase
  endfunction

  task automatic write_reg(logic [2:0] a, logic [7:0] d);
    wr_en = 1; wa = a; wd = d;
    @(posedge clk); model_write();
    @(negedge clk); wr_en = 0;
  endtask

  task automatic check_outputs(string tag);
    check({tag, " R1/R3/R4 enables"}, en, exp_en());
    check("R5 rst_ctl", rst_c, m_ctrl[7]);
    check("R5 pd_ctl", pd_c, m_ctrl[6]);
    check("R8 status", st, exp_rd(3'd0));
    check("R9 thr_pull", tpull, m_gate & ~thr & ~uvlo);
    check("R10 read", rd, exp_rd(ra));
  endtask

  // lockout cycle with given straps; codes load on release
  task automatic lockout_cycle(logic [1:0] b, logic [1:0] a);
    uvlo = 1; sb = b; sa = a;
    @(negedge clk); @(negedge clk);
    m_ctrl = 8'h00; m_gate = 1;
    uvlo = 0;
    @(posedge clk); model_load(b, a);
    @(negedge clk);
    check("R6 lin codes", lin, {m_l1, m_l2, m_l3, m_l4});
    check("R6 conva code", cva, m_cva);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    uvlo = 1; therm_c = 0; therm_l = 0; wr_en = 0; thr = 1; ramp = 0;
    pins = 0; pgood = 6'h3F; sa = 0; sb = 0; wa = 0; ra = 0; wd = 0;
    m_ctrl = 0; m_gate = 1; m_l1 = 0; m_l2 = 0; m_l3 = 0; m_l4 = 0; m_cva = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset / lockout state
    check("R2 reset enables", en, 6'd0);
    check("R5 reset rst_ctl", rst_c, 1'b0);
    check("R9 no pull in lockout", tpull, 1'b0);
    check("R8 reset status", st, 8'hBF);

    // R2: writes ignored in lockout
    write_reg(3'd1, 8'hFF);
    ra = 3'd1; #1;
    check("R2 ctrl write ignored", rd, 8'h00);
    pins = 6'h3F; #1;
    check("R2 enables off in lockout", en, 6'd0);
    pins = 0;
    @(negedge clk);

    // R6: all nine strap combos, float with hi both 0/1
    for (int b = 0; b < 3; b++) begin
      for (int a = 0; a < 3; a++) begin
        logic [1:0] pb, pa;
        pb = (b == 0) ? 2'b00 : (b == 1 ? {1'($urandom_range(0, 1)), 1'b1} : 2'b10);
        pa = (a == 0) ? 2'b00 : (a == 1 ? {1'($urandom_range(0, 1)), 1'b1} : 2'b10);
        lockout_cycle(pb, pa);
      end
    end

    // R7: strap change after load has no effect
    sa = 2'b10; sb = 2'b00;
    @(negedge clk); @(negedge clk);
    check("R7 straps ignored after load", {lin, cva}, {m_l1, m_l2, m_l3, m_l4, m_cva});
    write_reg(3'd4, 8'hC5);
    check("R7 conva write", cva, 6'h05);
    write_reg(3'd2, 8'h2B);
    check("R7 lin write", lin, {m_l1, m_l2, m_l3, m_l4});

    // R10: unmapped addresses
    write_reg(3'd6, 8'hAA);
    write_reg(3'd0, 8'h55);
    ra = 3'd6; #1; check("R10 unmapped 6", rd, 8'h00);
    ra = 3'd7; #1; check("R10 unmapped 7", rd, 8'h00);

    // R5: control outputs
    write_reg(3'd1, 8'h80);
    check("R5 rst released", {rst_c, pd_c}, 2'b10);
    write_reg(3'd1, 8'h40);
    check("R5 pd released", {rst_c, pd_c}, 2'b01);

    // R9: gate bit cleared disables pull
    thr = 0;
    write_reg(3'd5, 8'h00);
    check("R9 gate off", tpull, 1'b0);
    write_reg(3'd5, 8'h01);
    check("R9 gate on below threshold", tpull, 1'b1);

    // R3/R4 directed: thermal groups and resume
    write_reg(3'd1, 8'h00);
    pins = 6'h3F; therm_c = 1; #1;
    check("R3 converters off, linears on", en, 6'h0F);
    therm_c = 0; therm_l = 1; #1;
    check("R4 linears off, converters on", en, 6'h30);
    therm_l = 0; #1;
    check("R3 resume", en, 6'h3F);
    @(negedge clk);

    // random mix
    for (int it = 0; it < 3000; it++) begin
      pins = 6'($urandom); pgood = 6'($urandom);
      therm_c = ($urandom_range(0, 4) == 0);
      therm_l = ($urandom_range(0, 4) == 0);
      thr = 1'($urandom); ramp = 1'($urandom);
      ra = 3'($urandom);
      wr_en = ($urandom_range(0, 2) == 0);
      wa = ($urandom_range(0, 1) == 0) ? 3'd1 : 3'($urandom);
      wd = 8'($urandom);
      if ($urandom_range(0, 199) == 0) begin
        uvlo = 1;
        @(posedge clk); m_ctrl = 0; m_gate = 1;
        @(negedge clk); check_outputs("R2 rand lockout");
        uvlo = 0; wr_en = 0;
        @(posedge clk); model_load(sb, sa);
        @(negedge clk);
      end else begin
        @(posedge clk); model_write();
        @(negedge clk); wr_en = 0;
        check_outputs("rand");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule